// File: doc/BRIEF.md
# SPI Register-Access Host Sequencer

This block sits on the host side of an SPI link to a security-chip-style target and performs framed register reads and writes. A command port accepts a direction, an 8-bit register address and a byte count. The block builds the frame, streams write payload in from a byte-wide valid/ready input, and returns read bytes on a byte-wide valid/ready output. When the frame ends it reports the target's status byte, an error flag and a class code.

Every frame ends with a run of dummy bytes. The target needs this time before it can answer, and the number of dummy bytes is not fixed. After reset the block probes the target to find the smallest dummy count that works, then uses that count for every later frame. A target that never answers is flagged as absent, and the command port then stays closed.

Top module: `spi_reg_seq`

## Requirements
- R1: The first frame byte is 0x80 for a write (bit 7 is the direction flag) and 0x00 for a read. The second byte is the register address.
- R2: A write with a nonzero count to address 0x24 sends a 16-bit byte count, high byte first, between the address and the payload. Writes to other addresses, and writes with a zero count, carry no count field.
- R3: After the header and any payload, the host sends as many 0x00 bytes as the current latency setting. A read then sends one 0x00 byte for each requested data byte.
- R4: The status is the byte received during the last dummy byte. On a read, the bytes received after it are delivered in order on the read-data port.
- R5: Status classes are:
  - 0x5A gives class 0 with the error flag clear.
  - 0x86 and 0x89 give class 1.
  - 0x80 to 0x85, 0x8A, 0x8B and 0x90 give class 2.
  - 0x00 gives class 3.
  - Any other code gives class 4.

  The error flag is set for every status other than 0x5A.
- R6: After reset the block issues one-byte reads of address 0x14 with latency 1, 2, 3 and so on. It stops at the first nonzero status and adopts that latency. The command port is not ready while this search runs.
- R7: If latencies 1 through 15 all return status 0x00, the block raises the absent flag and the command port stays not ready.
- R8: SPI uses mode 0. The clock idles low and chip select stays low for the whole frame. Chip select goes high between frames.
- R9: The done output pulses for exactly one cycle per command frame. Probe frames do not raise it.
- R10: Holding the read-data ready low stalls the frame and loses no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle and calibrated |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 8 | Register address |
| cmd_len | input | LEN_W | Byte count |
| wr_valid | input | 1 | Payload byte valid |
| wr_ready | output | 1 | Payload byte taken |
| wr_data | input | 8 | Payload byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Read byte accepted |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle end-of-command pulse |
| status | output | 8 | Raw status of last command |
| err | output | 1 | Status was not success |
| err_class | output | 3 | Status class (R5) |
| latency | output | LAT_W | Latency found by calibration |
| cal_busy | output | 1 | Calibration in progress |
| absent | output | 1 | No latency worked |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | 1 | SPI chip select, active low |

## Verification
The bench models the target with a hidden latency. It answers 0x00 until the host has sent enough dummy bytes, so a block that stopped calibrating early or late would read the wrong status slot and report a wrong latency. FIFO writes with a zero and a nonzero count, and a write to a non-FIFO address, are aimed at the count-field rule; a design that always or never inserted the field would shift every later byte. Each status class is driven, and read data is taken under a random ready stall, which catches dropped or duplicated bytes. A second reset with an unreachable latency checks that the search gives up after fifteen tries and locks the command port.

// File: rtl/spi_reg_seq.sv
module spi_reg_seq #(
  parameter int          HALF_DIV   = 2,
  parameter int          LEN_W      = 12,
  parameter int          MAX_LAT    = 15,
  parameter logic [7:0]  FIFO_ADDR  = 8'h24,
  parameter logic [7:0]  PROBE_ADDR = 8'h14,
  parameter logic [7:0]  OK_CODE    = 8'h5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [7:0]       cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic [7:0]       status,
  output logic             err,
  output logic [2:0]       err_class,
  output logic [$clog2(MAX_LAT+1)-1:0] latency,
  output logic             cal_busy,
  output logic             absent,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);
  localparam int LAT_W = $clog2(MAX_LAT + 1);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_NEXT, S_LO, S_HI, S_POST, S_END, S_DEAD} st_t;
  typedef enum logic [2:0] {P_H0, P_H1, P_LH, P_LL, P_PAY, P_DUM, P_RD} ph_t;

  st_t              state;
  ph_t              phase;
  logic             f_wr, f_cal;
  logic [7:0]       f_addr, fstat, tx, rx;
  logic [LEN_W-1:0] f_len, cnt;
  logic [LAT_W-1:0] f_lat, lat_q;
  logic [DIV_W-1:0] div;
  logic [2:0]       bitc;
  logic [15:0]      len16;
  logic             rd_valid_q, has_rd, has_lenf, frame_end;

  function automatic logic [2:0] classify(input logic [7:0] c);
    case (c)
      OK_CODE:                                          classify = 3'd0;
      8'h86, 8'h89:                                     classify = 3'd1;
      8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85,
      8'h8A, 8'h8B, 8'h90:                              classify = 3'd2;
      8'h00:                                            classify = 3'd3;
      default:                                          classify = 3'd4;
    endcase
  endfunction

  assign len16     = 16'(f_len);
  assign has_rd    = !f_wr && (f_len != '0);
  assign has_lenf  = f_wr && (f_addr == FIFO_ADDR) && (f_len != '0);
  assign frame_end = (phase == P_DUM && cnt == LEN_W'(1) && !has_rd) ||
                     (phase == P_RD  && cnt == LEN_W'(1));
  assign cmd_ready = (state == S_IDLE);
  assign wr_ready  = (state == S_NEXT) && (phase == P_PAY) && wr_valid;
  assign mosi      = tx[7];
  assign rd_valid  = rd_valid_q;
  assign latency   = lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_START;
      phase      <= P_H0;
      f_wr       <= 1'b0;
      f_cal      <= 1'b1;
      f_addr     <= PROBE_ADDR;
      f_len      <= LEN_W'(1);
      f_lat      <= LAT_W'(1);
      lat_q      <= '0;
      cnt        <= '0;
      fstat      <= '0;
      tx         <= '0;
      rx         <= '0;
      div        <= '0;
      bitc       <= '0;
      cs_n       <= 1'b1;
      sclk       <= 1'b0;
      cal_busy   <= 1'b1;
      absent     <= 1'b0;
      done       <= 1'b0;
      status     <= '0;
      err        <= 1'b0;
      err_class  <= '0;
      rd_valid_q <= 1'b0;
      rd_data    <= '0;
    end else begin
      done <= 1'b0;
      if (rd_valid_q && rd_ready) rd_valid_q <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          f_wr   <= cmd_write;
          f_addr <= cmd_addr;
          f_len  <= cmd_len;
          f_lat  <= lat_q;
          f_cal  <= 1'b0;
          state  <= S_START;
        end
        S_START: begin
          cs_n  <= 1'b0;
          phase <= P_H0;
          state <= S_NEXT;
        end
        S_NEXT: begin
          div  <= '0;
          bitc <= '0;
          case (phase)
            P_H0:  begin tx <= f_wr ? 8'h80 : 8'h00; state <= S_LO; end
            P_H1:  begin tx <= f_addr;               state <= S_LO; end
            P_LH:  begin tx <= len16[15:8];          state <= S_LO; end
            P_LL:  begin tx <= len16[7:0];           state <= S_LO; end
            P_PAY: if (wr_valid) begin tx <= wr_data; state <= S_LO; end
            P_DUM: begin tx <= 8'h00;                state <= S_LO; end
            default: if (f_cal || !rd_valid_q) begin tx <= 8'h00; state <= S_LO; end
          endcase
        end
        S_LO: begin
          if (div == DIV_W'(HALF_DIV - 1)) begin
            div   <= '0;
            sclk  <= 1'b1;
            rx    <= {rx[6:0], miso};
            state <= S_HI;
          end else div <= div + 1'b1;
        end
        S_HI: begin
          if (div == DIV_W'(HALF_DIV - 1)) begin
            div  <= '0;
            sclk <= 1'b0;
            if (bitc == 3'd7) state <= S_POST;
            else begin
              bitc  <= bitc + 1'b1;
              tx    <= {tx[6:0], 1'b0};
              state <= S_LO;
            end
          end else div <= div + 1'b1;
        end
        S_POST: begin
          state <= frame_end ? S_END : S_NEXT;
          case (phase)
            P_H0: phase <= P_H1;
            P_H1: begin
              if (has_lenf) phase <= P_LH;
              else if (f_wr && f_len != '0) begin phase <= P_PAY; cnt <= f_len; end
              else begin phase <= P_DUM; cnt <= LEN_W'(f_lat); end
            end
            P_LH: phase <= P_LL;
            P_LL: begin phase <= P_PAY; cnt <= f_len; end
            P_PAY: begin
              cnt <= cnt - 1'b1;
              if (cnt == LEN_W'(1)) begin phase <= P_DUM; cnt <= LEN_W'(f_lat); end
            end
            P_DUM: begin
              cnt <= cnt - 1'b1;
              if (cnt == LEN_W'(1)) begin
                fstat <= rx;
                if (has_rd) begin phase <= P_RD; cnt <= f_len; end
              end
            end
            default: begin
              cnt <= cnt - 1'b1;
              if (!f_cal) begin rd_valid_q <= 1'b1; rd_data <= rx; end
            end
          endcase
        end
        S_END: begin
          cs_n <= 1'b1;
          if (f_cal) begin
            if (fstat != 8'h00) begin
              lat_q    <= f_lat;
              cal_busy <= 1'b0;
              state    <= S_IDLE;
            end else if (f_lat == LAT_W'(MAX_LAT)) begin
              absent   <= 1'b1;
              cal_busy <= 1'b0;
              state    <= S_DEAD;
            end else begin
              f_lat <= f_lat + 1'b1;
              state <= S_START;
            end
          end else begin
            done      <= 1'b1;
            status    <= fstat;
            err       <= (fstat != OK_CODE);
            err_class <= classify(fstat);
            state     <= S_IDLE;
          end
        end
        default: state <= S_DEAD;
      endcase
    end
  end
endmodule

// File: rtl/spi_reg_seq_chk.sv
module spi_reg_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       done,
  input logic [7:0] status,
  input logic       err,
  input logic [2:0] err_class,
  input logic       cmd_ready,
  input logic       cal_busy,
  input logic       absent,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R8
  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) done |-> cs_n); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
  AST_NO_DONE_CAL: assert property (@(posedge clk) disable iff (!rst_n) cal_busy |-> !done); // R9
  AST_CAL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) cal_busy |-> !cmd_ready); // R6
  AST_ABSENT_LOCK: assert property (@(posedge clk) disable iff (!rst_n) absent |-> (!cmd_ready && !cal_busy)); // R7
  AST_OK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (done && status == 8'h5A) |-> (!err && err_class == 3'd0)); // R5
  AST_BAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n) (done && status != 8'h5A) |-> err); // R5
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R10
endmodule

bind spi_reg_seq spi_reg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .done(done),
  .status(status), .err(err), .err_class(err_class), .cmd_ready(cmd_ready),
  .cal_busy(cal_busy), .absent(absent), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data)
);

// File: tb/sim_spi_reg_seq.sv
module sim_spi_reg_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cmd_valid, cmd_ready, cmd_write, wr_valid, wr_ready;
  logic [7:0]  cmd_addr, wr_data, rd_data, status;
  logic [11:0] cmd_len;
  logic        rd_valid, rd_ready, done, err, cal_busy, absent, sclk, mosi, miso, cs_n;
  logic [2:0]  err_class;
  logic [3:0]  latency;

  spi_reg_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .status(status), .err(err), .err_class(err_class),
    .latency(latency), .cal_busy(cal_busy), .absent(absent),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // target model
  int         tgt_lat, tgt_hdr, tgt_pl, tgt_len;
  bit         tgt_rd;
  logic [7:0] tgt_stat;
  logic [7:0] tgt_data[$];

  function automatic logic [7:0] resp(input int k);
    int s = tgt_hdr + tgt_pl + tgt_lat - 1;
    if (k == s) return tgt_stat;
    if (tgt_rd && k > s && k <= s + tgt_len) return tgt_data[k-s-1];
    return 8'h00;
  endfunction

  int         s_bit, s_byte, frames;
  logic [7:0] s_tx, s_rx;
  logic [7:0] cur_frame[$], last_frame[$];

  always @(negedge cs_n) begin
    s_bit = 0; s_byte = 0; s_tx = resp(0); miso = s_tx[7]; cur_frame.delete();
  end
  always @(posedge cs_n) begin
    last_frame = cur_frame; frames++;
  end
  always @(posedge sclk) if (!cs_n) begin
    s_rx = {s_rx[6:0], mosi};
    s_bit++;
    if (s_bit == 8) begin cur_frame.push_back(s_rx); s_byte++; s_bit = 0; end
  end
  always @(negedge sclk) if (!cs_n) begin
    if (s_bit == 0) s_tx = resp(s_byte);
    miso = s_tx[7-s_bit];
  end

  // payload source and read sink
  logic [7:0] pay_q[$], rd_got[$];
  bit take = 0, stall_mode = 0;
  int outstanding = 0, cyc_bad = 0;
  always @(negedge clk) begin
    if (take) begin void'(pay_q.pop_front()); take = 0; end
    wr_valid = (pay_q.size() > 0);
    wr_data  = wr_valid ? pay_q[0] : 8'h00;
    if (wr_valid && wr_ready) take = 1;
    rd_ready = stall_mode ? (($urandom % 3) == 0) : 1'b1;
    if (rd_valid && rd_ready) rd_got.push_back(rd_data);
    if (rst_n) begin
      if (cs_n && sclk) cyc_bad++;
      if (done && outstanding == 0) cyc_bad++;
      if (done) outstanding--;
    end
  end

  function automatic int exp_class(input logic [7:0] s);
    if (s == 8'h5A) return 0;
    if (s == 8'h89 || s == 8'h86) return 1;
    if (s == 8'h00) return 3;
    if ((s >= 8'h80 && s <= 8'h85) || s == 8'h8A || s == 8'h8B || s == 8'h90) return 2;
    return 4;
  endfunction

  task automatic cmp_frame(input logic [7:0] e[$], input string req);
    int bad = -1;
    chk(last_frame.size() == e.size(), req, "frame length", last_frame.size(), e.size());
    if (last_frame.size() == e.size())
      foreach (e[i]) if (bad < 0 && last_frame[i] !== e[i]) bad = i;
    if (bad >= 0) chk(0, req, $sformatf("frame byte %0d", bad), last_frame[bad], e[bad]);
    else chk(1, req, "frame bytes", 0, 0);
  endtask

  task automatic run_cmd(input bit w, input logic [7:0] a, input int n,
                         input logic [7:0] st, input bit stall, input string req);
    logic [7:0] e[$];
    logic [7:0] pl[$];
    for (int i = 0; i < n; i++) pl.push_back(8'($urandom));
    tgt_rd  = !w;
    tgt_hdr = 2 + ((w && a == 8'h24 && n > 0) ? 2 : 0);
    tgt_pl  = w ? n : 0;
    tgt_len = w ? 0 : n;
    tgt_stat = st;
    tgt_data.delete();
    if (!w) tgt_data = pl;
    rd_got.delete();
    stall_mode = stall;
    e.push_back(w ? 8'h80 : 8'h00);
    e.push_back(a);
    if (w && a == 8'h24 && n > 0) begin e.push_back(8'(n >> 8)); e.push_back(8'(n)); end
    if (w) foreach (pl[i]) e.push_back(pl[i]);
    for (int i = 0; i < tgt_lat; i++) e.push_back(8'h00);
    if (!w) for (int i = 0; i < n; i++) e.push_back(8'h00);
    @(negedge clk);
    if (w) pay_q = pl;
    cmd_write = w; cmd_addr = a; cmd_len = 12'(n); cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1 cmd_valid = 1'b0;
    outstanding++;
    while (!done) @(negedge clk);
    chk(status == st, "R4", "status byte", status, st);
    chk(err == (st != 8'h5A), "R5", "error flag", err, (st != 8'h5A));
    chk(int'(err_class) == exp_class(st), "R5", "class", err_class, exp_class(st));
    repeat (40) @(negedge clk);
    cmp_frame(e, req);
    if (!w) begin
      bit ok = (rd_got.size() == n);
      if (ok) foreach (pl[i]) if (rd_got[i] !== pl[i]) ok = 0;
      chk(ok, stall ? "R10" : "R4", "read data", rd_got.size(), n);
    end
    stall_mode = 0;
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] e[$];
    rst_n = 0; cmd_valid = 0; cmd_write = 0; cmd_addr = 0; cmd_len = 0; miso = 0;
    tgt_lat = 3; tgt_rd = 1; tgt_hdr = 2; tgt_pl = 0; tgt_len = 1; tgt_stat = 8'h5A;
    tgt_data = '{8'hC3};
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0, "R8", "reset lines", {cs_n, sclk}, 2'b10);
    chk(cmd_ready === 1'b0 && done === 1'b0, "R6", "reset port", {cmd_ready, done}, 0);
    frames = 0;
    rst_n = 1;
    while (!cmd_ready) @(negedge clk);
    // R6: probe search stops at the target's latency
    chk(frames == 3, "R6", "probe frames", frames, 3);
    chk(latency == 4'd3, "R6", "latency", latency, 3);
    e = '{8'h00, 8'h14, 8'h00, 8'h00, 8'h00, 8'h00};
    cmp_frame(e, "R6");
    chk(absent == 1'b0 && cal_busy == 1'b0, "R7", "present", {absent, cal_busy}, 0);

    run_cmd(0, 8'h0C, 4, 8'h5A, 0, "R1");   // plain read
    run_cmd(1, 8'h08, 1, 8'h5A, 0, "R1");   // write, no count field
    run_cmd(1, 8'h24, 3, 8'h89, 0, "R2");   // FIFO write with count, size error
    run_cmd(1, 8'h24, 0, 8'h85, 0, "R2");   // FIFO write, zero count
    run_cmd(0, 8'h30, 0, 8'h00, 0, "R3");   // read, zero count, no answer
    run_cmd(0, 8'h18, 2, 8'h77, 0, "R3");   // unknown code
    run_cmd(1, 8'h24, 300, 8'h90, 0, "R2"); // count above 255
    run_cmd(0, 8'h24, 6, 8'h86, 1, "R10");  // stalled read
    chk(cyc_bad == 0, "R9", "per-cycle idle and done monitor", cyc_bad, 0);

    // R7: target never answers in range
    @(negedge clk);
    rst_n = 0;
    tgt_lat = 20; tgt_rd = 1; tgt_hdr = 2; tgt_pl = 0; tgt_len = 1; tgt_stat = 8'h5A;
    repeat (2) @(negedge clk);
    frames = 0;
    rst_n = 1;
    while (cal_busy) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(absent == 1'b1, "R7", "absent flag", absent, 1);
    chk(cmd_ready == 1'b0, "R7", "port closed", cmd_ready, 0);
    chk(frames == 15, "R7", "probe frames", frames, 15);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule